// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block turns a serial receive line into parallel characters. It runs on the system clock. A single-cycle enable arrives at sixteen times the bit rate, and the line is examined only on those enable cycles. A falling edge on the line is treated as a start bit only if the line is still low half a bit later. After that, every data bit, the optional parity or address/data bit, and the stop bit is sampled once at the centre of its bit time. Data bits arrive least significant first.

Each finished character is handed to a downstream queue in one step: a single-cycle write strobe, with the data byte and three status flags valid on the same cycle. The flags are parity error, framing error and break. Mode inputs select the character length, the parity scheme, the parity sense and an address-wake mode. The mode inputs are expected to stay stable while a character is being received.

The receiver has two abort controls: an enable input and a one-cycle reset command. It also covers several line conditions:
- A low stop bit can lead straight into the next character.
- A held-low line produces exactly one break character.
- In wake mode, a disabled receiver keeps listening and passes on only address-flagged characters.

Top module: `ovs_uart_rx`

## Requirements
- R1: A start is detected on a 16x tick where the line sampled on the previous tick was high and is now low. The line is sampled again 8 ticks later. If it is high there, the start is rejected, no character is produced and edge search resumes.
- R2: After a confirmed start, each later bit is sampled every 16 ticks, least significant data bit first. `len_sel_i` gives 5 + `len_sel_i` data bits (00=5 … 11=8). Stored bits above the character length are zero.
- R3: `par_mode_i` encoding: 00 = parity checked, 01 = forced parity level, 10 = no parity bit, 11 = address-wake. With 00, `par_type_i`=0 expects even parity over the data bits and `par_type_i`=1 expects odd. A mismatch sets `q_perr_o`. With 10 there is no parity bit and `q_perr_o` is 0.
- R4: With mode 01, the received parity-position bit must equal `par_type_i`, otherwise `q_perr_o` is 1.
- R5: A stop bit sampled low sets `q_ferr_o`. Every character appears as a one-cycle `q_wr_o` pulse, with data and all flags valid in that same cycle.
- R6: After a high stop bit, edge search resumes at once, so frames with one stop bit and no idle gap are all received.
- R7: After a low stop bit on a character that is not a break, the line is sampled 8 ticks later. If it is low, that tick counts as a detected start edge.
- R8: If the data bits, the parity-position bit (when present) and the stop bit are all low, exactly one character 0x00 is stored with `q_brk_o`=1 and `q_ferr_o`=1. Nothing more is stored until the line is high on two consecutive ticks.
- R9: With `rx_en_i` low (outside mode 11), a character in progress is abandoned within one clock and not stored. After re-enable, reception starts at the next falling edge.
- R10: A one-cycle `rx_flush_i` returns the receiver to edge search within one clock and discards the partial character.
- R11: In mode 11, the parity-position bit is reported on `q_perr_o`. With `rx_en_i`=0, characters with that bit 0 are dropped unless they are breaks, and those with it 1 are stored. With `rx_en_i`=1 every character is stored.
- R12: After reset, `q_wr_o` is low and nothing is stored until a valid frame arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Serial receive line, idle high |
| tick16_i | input | 1 | One-cycle enable at 16x the bit rate |
| rx_en_i | input | 1 | Receiver enable |
| rx_flush_i | input | 1 | One-cycle receiver reset command |
| len_sel_i | input | 2 | Data bits minus five |
| par_mode_i | input | 2 | Parity scheme (see R3) |
| par_type_i | input | 1 | Odd parity / forced level |
| q_wr_o | output | 1 | Queue write strobe |
| q_data_o | output | 8 | Received character |
| q_perr_o | output | 1 | Parity error, or address flag in wake mode |
| q_ferr_o | output | 1 | Framing error |
| q_brk_o | output | 1 | Break detected |

## Verification
The bench drives a low glitch shorter than half a bit. A receiver that skipped start revalidation would assemble a spurious character from it. It sends a character with a low stop bit immediately followed by another character; without the half-bit restart the second character is lost. After a break, it gives the line a single-tick high pulse and then holds it low again. A receiver that left break wait on one high sample would store a second break character. Aborts by disable and by flush are driven in the middle of an all-ones character, and wake-mode filtering is checked in both enable states; a design that did not abort or did not filter stores a character that must not appear.

// File: rtl/ovs_rx_pkg.sv
package ovs_rx_pkg;

  localparam int DATA_W  = 8;
  localparam int LEN_W   = 2;
  localparam int MIN_LEN = 5;

  localparam logic [1:0] PM_CHECK = 2'b00;
  localparam logic [1:0] PM_FORCE = 2'b01;
  localparam logic [1:0] PM_NONE  = 2'b10;
  localparam logic [1:0] PM_WAKE  = 2'b11;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_HALF,
    S_BRKW
  } rx_state_e;

  // Mask of the bits a character of the selected length may use.
  function automatic logic [DATA_W-1:0] len_mask(input logic [LEN_W-1:0] ls);
    logic [DATA_W-1:0] m;
    m = '1;
    return m >> (2'd3 - ls);
  endfunction

  // Expected level of the parity-position bit (unused data bits are zero).
  function automatic logic exp_par_bit(input logic [DATA_W-1:0] d,
                                       input logic [1:0] mode,
                                       input logic typ);
    if (mode == PM_FORCE) return typ;
    return (^d) ^ typ;
  endfunction

endpackage

// File: rtl/ovs_rx_sync.sv
module ovs_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd_i,
  input  logic tick_i,
  output logic line_o,
  output logic fall_o
);

  logic [STAGES-1:0] pipe_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '1;
      prev_q <= 1'b1;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], rxd_i};
      if (tick_i) prev_q <= pipe_q[STAGES-1];
    end
  end

  assign line_o = pipe_q[STAGES-1];
  assign fall_o = tick_i & prev_q & ~line_o;

endmodule

// File: rtl/ovs_rx_framer.sv
module ovs_rx_framer
  import ovs_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic              fall_i,
  input  logic              run_i,
  input  logic              flush_i,
  input  logic [LEN_W-1:0]  len_sel_i,
  input  logic              has_par_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              par_o,
  output logic              stop_o
);

  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] FULL_LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(OSR / 2 - 1);
  localparam int IW = $clog2(DATA_W);

  rx_state_e         st_q;
  logic [CW-1:0]     cnt_q;
  logic [IW-1:0]     bidx_q;
  logic [DATA_W-1:0] sh_q;
  logic              par_q;
  logic              stop_q;
  logic [1:0]        hi_cnt_q;

  logic [IW-1:0] last_idx;
  logic          half_phase;
  logic          samp_evt;
  logic          start_reject;
  logic          zero_char;

  assign last_idx     = IW'(MIN_LEN - 1) + IW'(len_sel_i);
  assign half_phase   = (st_q == S_START) || (st_q == S_HALF);
  assign samp_evt     = tick_i && (cnt_q == (half_phase ? HALF_LAST : FULL_LAST));
  assign start_reject = (st_q == S_START) && samp_evt && line_i;
  assign zero_char    = (sh_q == '0) && !(has_par_i && par_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      cnt_q    <= '0;
      bidx_q   <= '0;
      sh_q     <= '0;
      par_q    <= 1'b0;
      stop_q   <= 1'b1;
      hi_cnt_q <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (flush_i || !run_i) begin
        st_q     <= S_IDLE;
        cnt_q    <= '0;
        bidx_q   <= '0;
        sh_q     <= '0;
        par_q    <= 1'b0;
        hi_cnt_q <= '0;
      end else if (tick_i) begin
        case (st_q)
          S_IDLE: begin
            if (fall_i) begin
              st_q  <= S_START;
              cnt_q <= '0;
            end
          end
          S_START: begin
            if (samp_evt) begin
              cnt_q <= '0;
              if (start_reject) begin
                st_q <= S_IDLE;
              end else begin
                st_q   <= S_DATA;
                bidx_q <= '0;
                sh_q   <= '0;
                par_q  <= 1'b0;
              end
            end else cnt_q <= cnt_q + CW'(1);
          end
          S_DATA: begin
            if (samp_evt) begin
              cnt_q        <= '0;
              sh_q[bidx_q] <= line_i;
              if (bidx_q == last_idx) st_q <= has_par_i ? S_PAR : S_STOP;
              else bidx_q <= bidx_q + IW'(1);
            end else cnt_q <= cnt_q + CW'(1);
          end
          S_PAR: begin
            if (samp_evt) begin
              cnt_q <= '0;
              par_q <= line_i;
              st_q  <= S_STOP;
            end else cnt_q <= cnt_q + CW'(1);
          end
          S_STOP: begin
            if (samp_evt) begin
              cnt_q  <= '0;
              stop_q <= line_i;
              done_o <= 1'b1;
              if (line_i) st_q <= S_IDLE;
              else if (zero_char) begin
                st_q     <= S_BRKW;
                hi_cnt_q <= '0;
              end else st_q <= S_HALF;
            end else cnt_q <= cnt_q + CW'(1);
          end
          S_HALF: begin
            if (samp_evt) begin
              cnt_q <= '0;
              st_q  <= line_i ? S_IDLE : S_START;
            end else cnt_q <= cnt_q + CW'(1);
          end
          S_BRKW: begin
            if (line_i) begin
              if (hi_cnt_q == 2'd1) st_q <= S_IDLE;
              hi_cnt_q <= hi_cnt_q + 2'd1;
            end else hi_cnt_q <= '0;
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  assign data_o = sh_q;
  assign par_o  = par_q;
  assign stop_o = stop_q;

  // R10
  flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> st_q == S_IDLE);

  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> st_q == S_IDLE);

  // R1
  start_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_reject |=> st_q == S_IDLE);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  brk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_BRKW) && tick_i && !line_i && run_i && !flush_i |=> st_q == S_BRKW);

endmodule

// File: rtl/ovs_rx_status.sv
module ovs_rx_status
  import ovs_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  input  logic              stop_i,
  input  logic [1:0]        par_mode_i,
  input  logic              par_type_i,
  input  logic              rx_en_i,
  output logic              q_wr_o,
  output logic [DATA_W-1:0] q_data_o,
  output logic              q_perr_o,
  output logic              q_ferr_o,
  output logic              q_brk_o
);

  logic is_wake, has_par, brk_w, perr_w, keep_w;

  always_comb begin
    is_wake = (par_mode_i == PM_WAKE);
    has_par = (par_mode_i != PM_NONE);
    brk_w   = !stop_i && (data_i == '0) && !(has_par && par_i);
    if (is_wake)      perr_w = par_i;
    else if (has_par) perr_w = par_i != exp_par_bit(data_i, par_mode_i, par_type_i);
    else              perr_w = 1'b0;
    keep_w  = !(is_wake && !rx_en_i && !par_i && !brk_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_wr_o   <= 1'b0;
      q_data_o <= '0;
      q_perr_o <= 1'b0;
      q_ferr_o <= 1'b0;
      q_brk_o  <= 1'b0;
    end else begin
      q_wr_o <= done_i && keep_w;
      if (done_i && keep_w) begin
        q_data_o <= data_i;
        q_perr_o <= perr_w;
        q_ferr_o <= !stop_i;
        q_brk_o  <= brk_w;
      end
    end
  end

  // R8
  brk_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_wr_o && q_brk_o |-> (q_data_o == '0) && q_ferr_o);

  // R11
  wake_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_wr_o && $past(par_mode_i == PM_WAKE && !rx_en_i) |-> q_perr_o || q_brk_o);

  // R3
  none_perr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_wr_o && $past(par_mode_i == PM_NONE) |-> !q_perr_o);

endmodule

// File: rtl/ovs_uart_rx.sv
module ovs_uart_rx
  import ovs_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd_i,
  input  logic              tick16_i,
  input  logic              rx_en_i,
  input  logic              rx_flush_i,
  input  logic [LEN_W-1:0]  len_sel_i,
  input  logic [1:0]        par_mode_i,
  input  logic              par_type_i,
  output logic              q_wr_o,
  output logic [DATA_W-1:0] q_data_o,
  output logic              q_perr_o,
  output logic              q_ferr_o,
  output logic              q_brk_o
);

  logic              line, fall_evt, run, has_par;
  logic              char_done, char_par, char_stop;
  logic [DATA_W-1:0] char_data;

  assign run     = rx_en_i || (par_mode_i == PM_WAKE);
  assign has_par = (par_mode_i != PM_NONE);

  ovs_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rxd_i  (rxd_i),
    .tick_i (tick16_i),
    .line_o (line),
    .fall_o (fall_evt)
  );

  ovs_rx_framer #(.OSR(OSR)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick16_i),
    .line_i    (line),
    .fall_i    (fall_evt),
    .run_i     (run),
    .flush_i   (rx_flush_i),
    .len_sel_i (len_sel_i),
    .has_par_i (has_par),
    .done_o    (char_done),
    .data_o    (char_data),
    .par_o     (char_par),
    .stop_o    (char_stop)
  );

  ovs_rx_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_i     (char_done),
    .data_i     (char_data),
    .par_i      (char_par),
    .stop_i     (char_stop),
    .par_mode_i (par_mode_i),
    .par_type_i (par_type_i),
    .rx_en_i    (rx_en_i),
    .q_wr_o     (q_wr_o),
    .q_data_o   (q_data_o),
    .q_perr_o   (q_perr_o),
    .q_ferr_o   (q_ferr_o),
    .q_brk_o    (q_brk_o)
  );

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_wr_o |-> (q_data_o & ~len_mask(len_sel_i)) == '0);

endmodule

// File: tb/ovs_uart_rx_bench.sv
module ovs_uart_rx_bench;

  localparam int BIT = 64;  // 16 ticks of 4 clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       tick = 1'b0;
  logic       rx_en = 1'b1;
  logic       flush = 1'b0;
  logic [1:0] len_sel = 2'd3;
  logic [1:0] pmode = 2'b10;
  logic       ptype = 1'b0;
  logic       q_wr, q_perr, q_ferr, q_brk;
  logic [7:0] q_data;
  logic [1:0] tdiv = 2'd0;

  int nchk = 0, nerr = 0, ncap = 0, seen = 0;
  logic [7:0] cap_data [0:255];
  logic       cap_perr [0:255];
  logic       cap_ferr [0:255];
  logic       cap_brk  [0:255];

  ovs_uart_rx u_ovs_uart_rx (
    .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .tick16_i(tick), .rx_en_i(rx_en),
    .rx_flush_i(flush), .len_sel_i(len_sel), .par_mode_i(pmode), .par_type_i(ptype),
    .q_wr_o(q_wr), .q_data_o(q_data), .q_perr_o(q_perr), .q_ferr_o(q_ferr), .q_brk_o(q_brk)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    tdiv <= tdiv + 2'd1;
    tick <= (tdiv == 2'd3);
  end

  always @(negedge clk) begin
    if (rst_n && q_wr && ncap < 256) begin
      cap_data[ncap] = q_data;
      cap_perr[ncap] = q_perr;
      cap_ferr[ncap] = q_ferr;
      cap_brk[ncap]  = q_brk;
      ncap = ncap + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic line_for(input logic v, input int clocks);
    rxd = v;
    repeat (clocks) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int len, input logic has_p,
                            input logic pbit, input logic stopb);
    line_for(1'b0, BIT);
    for (int i = 0; i < len; i++) line_for(d[i], BIT);
    if (has_p) line_for(pbit, BIT);
    line_for(stopb, BIT);
  endtask

  task automatic gap();
    line_for(1'b1, 3 * BIT);
  endtask

  task automatic expect_count(input int n, input string req);
    chk(ncap == seen + n, req, "character count", ncap, seen + n);
  endtask

  task automatic expect_at(input int idx, input logic [7:0] d, input logic pe,
                           input logic fe, input logic bk, input string req);
    int act, exp;
    act = (idx < 256) ? int'({cap_data[idx], cap_perr[idx], cap_ferr[idx], cap_brk[idx]}) : -1;
    exp = int'({d, pe, fe, bk});
    chk(act == exp, req, "character {data,perr,ferr,brk}", act, exp);
  endtask

  task automatic resync();
    seen = ncap;
  endtask

  // Bench-side parity: count ones over the data bits of the chosen length.
  function automatic logic want_pbit(input logic [7:0] d, input int len,
                                     input logic [1:0] mode, input logic typ);
    int ones = 0;
    for (int i = 0; i < len; i++) ones += int'(d[i]);
    if (mode == 2'b01) return typ;
    if (typ) return (ones % 2) == 0;
    return (ones % 2) == 1;
  endfunction

  logic done = 1'b0;

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (200) @(negedge clk);

    // R12: reset state
    chk(q_wr == 1'b0, "R12", "q_wr_o after reset", int'(q_wr), 0);
    chk(ncap == 0, "R12", "no character after reset", ncap, 0);

    // R2: plain 8-bit character, no parity
    resync();
    send_frame(8'hA5, 8, 1'b0, 1'b0, 1'b1); gap();
    expect_count(1, "R2");
    expect_at(seen, 8'hA5, 1'b0, 1'b0, 1'b0, "R2");

    // R6: back-to-back frames without idle
    resync();
    send_frame(8'h3C, 8, 1'b0, 1'b0, 1'b1);
    send_frame(8'hC3, 8, 1'b0, 1'b0, 1'b1); gap();
    expect_count(2, "R6");
    expect_at(seen, 8'h3C, 1'b0, 1'b0, 1'b0, "R6");
    expect_at(seen + 1, 8'hC3, 1'b0, 1'b0, 1'b0, "R6");

    // R1: short low glitch rejected, then a valid frame
    resync();
    line_for(1'b0, 24); gap();
    expect_count(0, "R1");
    send_frame(8'h5A, 8, 1'b0, 1'b0, 1'b1); gap();
    expect_count(1, "R1");
    expect_at(seen, 8'h5A, 1'b0, 1'b0, 1'b0, "R1");

    // R5 / R7: low stop bit, next frame starts right away
    resync();
    send_frame(8'h81, 8, 1'b0, 1'b0, 1'b0);
    send_frame(8'h42, 8, 1'b0, 1'b0, 1'b1); gap();
    expect_count(2, "R7");
    expect_at(seen, 8'h81, 1'b0, 1'b1, 1'b0, "R5");
    expect_at(seen + 1, 8'h42, 1'b0, 1'b0, 1'b0, "R7");

    // R8: break, one-tick high pulse, low again, then release
    resync();
    line_for(1'b0, 25 * BIT);
    line_for(1'b1, 4);
    line_for(1'b0, 20 * BIT);
    gap();
    expect_count(1, "R8");
    expect_at(seen, 8'h00, 1'b0, 1'b1, 1'b1, "R8");
    resync();
    send_frame(8'h99, 8, 1'b0, 1'b0, 1'b1); gap();
    expect_count(1, "R8");
    expect_at(seen, 8'h99, 1'b0, 1'b0, 1'b0, "R8");

    // R9: disable mid-character
    resync();
    line_for(1'b0, BIT);
    line_for(1'b1, 3 * BIT);
    rx_en = 1'b0; line_for(1'b1, 10);
    rx_en = 1'b1; line_for(1'b1, 6 * BIT);
    gap();
    expect_count(0, "R9");
    send_frame(8'h17, 8, 1'b0, 1'b0, 1'b1); gap();
    expect_count(1, "R9");
    expect_at(seen, 8'h17, 1'b0, 1'b0, 1'b0, "R9");

    // R10: flush mid-character
    resync();
    line_for(1'b0, BIT);
    line_for(1'b1, 4 * BIT);
    flush = 1'b1; line_for(1'b1, 1);
    flush = 1'b0; line_for(1'b1, 5 * BIT);
    gap();
    expect_count(0, "R10");
    send_frame(8'h2E, 8, 1'b0, 1'b0, 1'b1); gap();
    expect_count(1, "R10");
    expect_at(seen, 8'h2E, 1'b0, 1'b0, 1'b0, "R10");

    // R3: 7-bit even then odd parity on 0x35 (four ones), parity bit sent 0
    resync();
    len_sel = 2'd2; pmode = 2'b00; ptype = 1'b0;
    send_frame(8'h35, 7, 1'b1, 1'b0, 1'b1); gap();
    ptype = 1'b1;
    send_frame(8'h35, 7, 1'b1, 1'b0, 1'b1); gap();
    expect_count(2, "R3");
    expect_at(seen, 8'h35, 1'b0, 1'b0, 1'b0, "R3");
    expect_at(seen + 1, 8'h35, 1'b1, 1'b0, 1'b0, "R3");

    // R4: forced level 1, 5-bit character; sent 1 then 0
    resync();
    len_sel = 2'd0; pmode = 2'b01; ptype = 1'b1;
    send_frame(8'hFF, 5, 1'b1, 1'b1, 1'b1); gap();
    send_frame(8'h0A, 5, 1'b1, 1'b0, 1'b1); gap();
    expect_count(2, "R4");
    expect_at(seen, 8'h1F, 1'b0, 1'b0, 1'b0, "R4");
    expect_at(seen + 1, 8'h0A, 1'b1, 1'b0, 1'b0, "R4");

    // R11: address-wake filtering
    resync();
    len_sel = 2'd3; pmode = 2'b11; ptype = 1'b0; rx_en = 1'b0;
    send_frame(8'h11, 8, 1'b1, 1'b1, 1'b1); gap();
    send_frame(8'h22, 8, 1'b1, 1'b0, 1'b1); gap();
    rx_en = 1'b1;
    send_frame(8'h33, 8, 1'b1, 1'b0, 1'b1); gap();
    rx_en = 1'b0;
    line_for(1'b0, 12 * BIT); gap();
    expect_count(3, "R11");
    expect_at(seen, 8'h11, 1'b1, 1'b0, 1'b0, "R11");
    expect_at(seen + 1, 8'h33, 1'b0, 1'b0, 1'b0, "R11");
    expect_at(seen + 2, 8'h00, 1'b0, 1'b1, 1'b1, "R11");
    rx_en = 1'b1;

    // Random mix (R2, R3, R4, R5, R11)
    for (int it = 0; it < 100; it++) begin
      logic [1:0] ls, pm;
      logic       pt, hp, pb, inj, stb;
      logic [7:0] d, m;
      int         len;
      ls  = 2'($urandom % 4);
      pm  = 2'($urandom % 4);
      pt  = 1'($urandom % 2);
      len = 5 + int'(ls);
      m   = 8'hFF >> (3 - int'(ls));
      d   = 8'($urandom) & m;
      hp  = (pm != 2'b10);
      inj = (($urandom % 4) == 0);
      pb  = (pm == 2'b11) ? 1'($urandom % 2) : (want_pbit(d, len, pm, pt) ^ inj);
      stb = 1'b1;
      if ((($urandom % 8) == 0) && (d != 8'h00 || (hp && pb))) stb = 1'b0;
      len_sel = ls; pmode = pm; ptype = pt; rx_en = 1'b1;
      resync();
      send_frame(d, len, hp, pb, stb); gap();
      expect_count(1, "R2");
      if (pm == 2'b11)      expect_at(seen, d, pb, !stb, 1'b0, "R11");
      else if (pm == 2'b10) expect_at(seen, d, 1'b0, !stb, 1'b0, "R5");
      else if (pm == 2'b01) expect_at(seen, d, inj, !stb, 1'b0, "R4");
      else                  expect_at(seen, d, inj, !stb, 1'b0, "R3");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule